// File: doc/BRIEF.md
# SPI Host Output Pad Monitor

This block watches the three outputs an SPI controller drives in host mode (chip-select 0, serial data out and serial clock) and compares each internal drive value with the level read back from its pad. A disagreement that lasts long enough points to a stuck line, a wrongly routed IO multiplexer, a failed pad buffer or a shorted board trace. The block reports the fault and never touches the transmit path.

The pad readbacks are brought into the clock domain through a synchronizer. The drive values and the control flags are delayed by the same number of stages, so that every comparison pairs values from the same cycle. The check runs only while the controller is in host mode and a character is on the line. The data-out line takes part only when its own check enable is set. A mismatch must persist for a programmable number of consecutive cycles before it counts, so a single upset is filtered out. The cycle right after each change of the transmit-active flag is not compared, which hides the edges at character boundaries.

A confirmed fault sets two sticky flags: a pad-error flag and a summary safety-error flag. Each flag has its own clear-on-read pulse. The interrupt request is the safety-error flag gated by its enable. Software cannot switch the monitor off.

Top module: `spi_pad_monitor`

## Requirements
- R1: After reset, pad_err_o, safety_err_o and irq_o are 0.
- R2: With host_mode_i=1 and tx_active_i=1, a mismatch between drv_cs0_i and pad_cs0_i, or between drv_sck_i and pad_sck_i, held for at least FAULT_THRESH (default 2) consecutive clock cycles sets both pad_err_o and safety_err_o.
- R3: A mismatch that lasts for fewer than FAULT_THRESH consecutive cycles sets no flag. This includes isolated one-cycle glitches that are separated by matching cycles.
- R4: No flag is set while host_mode_i=0 or tx_active_i=0, whatever the mismatches.
- R5: The data-out pair (drv_mosi_i, pad_mosi_i) is compared only when mosi_chk_en_i=1. With mosi_chk_en_i=1, a persistent data-out mismatch sets the flags exactly as in R2.
- R6: The first cycle after any change of tx_active_i is not compared. A 2-cycle mismatch that starts together with the rise of tx_active_i sets no flag, and a 3-cycle mismatch does.
- R7: The flags are sticky. pad_clr_i clears only pad_err_o and sec_clr_i clears only safety_err_o, one cycle after the pulse.
- R8: When a confirmed fault and a clear pulse fall in the same cycle, the flag stays set.
- R9: irq_o is 1 exactly when safety_err_o=1 and irq_en_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode_i | input | 1 | Controller is in host mode |
| tx_active_i | input | 1 | Transmitter enabled and a character in flight |
| mosi_chk_en_i | input | 1 | Include the data-out line in the comparison |
| irq_en_i | input | 1 | Interrupt enable for the safety error |
| drv_cs0_i | input | 1 | Internal chip-select 0 drive value |
| drv_mosi_i | input | 1 | Internal data-out drive value |
| drv_sck_i | input | 1 | Internal serial-clock drive value |
| pad_cs0_i | input | 1 | Chip-select 0 pad readback (asynchronous) |
| pad_mosi_i | input | 1 | Data-out pad readback (asynchronous) |
| pad_sck_i | input | 1 | Serial-clock pad readback (asynchronous) |
| pad_clr_i | input | 1 | Clear-on-read pulse for pad_err_o |
| sec_clr_i | input | 1 | Clear-on-read pulse for safety_err_o |
| pad_err_o | output | 1 | Sticky pad-error flag |
| safety_err_o | output | 1 | Sticky summary safety-error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A clear pulse and a freshly confirmed fault can land in the same cycle. The bench provokes this by holding a chip-select mismatch long enough that the fault is confirmed again on every cycle, and then pulsing both clears. Both flags must read 1 afterwards. Once the mismatch is removed, the same clears must drop both flags. The rise of tx_active_i can also coincide with the start of a mismatch. That case is judged by comparing a 2-cycle burst, which the blanked first cycle must hide, with a 3-cycle burst, which must be reported.

// File: rtl/spi_mon_pkg.sv
// Shared constants for the SPI host output pad monitor.
// Assumes exactly three monitored lines, in the index order given below.
package spi_mon_pkg;
    localparam int unsigned N_LINES = 3;
    localparam int unsigned LN_CS0  = 0;
    localparam int unsigned LN_MOSI = 1;
    localparam int unsigned LN_SCK  = 2;
    typedef logic [N_LINES-1:0] line_vec_t;
endpackage

// File: rtl/spi_mon_align.sv
// Delay line of STAGES flops for a W-bit bundle.
// It serves as the two-flop synchronizer for the pad readbacks and as the
// matching delay for the drive values and control flags.
// Assumes STAGES >= 1.
module spi_mon_align #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    // Shift the bundle one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_mon_filter.sv
// Persistence filter, one counter per line.
// A line reports a hit once its qualified mismatch has been present for
// THRESH consecutive cycles, including the current one. The hit repeats
// on every cycle while the mismatch lasts.
// Assumes THRESH >= 1.
module spi_mon_filter
    import spi_mon_pkg::*;
#(
    parameter int unsigned THRESH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t chk_i,
    output logic      hit_o
);
    localparam int unsigned CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(THRESH);
    localparam logic [CW-1:0] CNT_TRIG = CW'(THRESH - 1);

    line_vec_t hit_vec;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [CW-1:0] run_cnt;

        // Count consecutive mismatch cycles, saturating at THRESH.
        always_ff @(posedge clk) begin
            if (!rst_n)              run_cnt <= '0;
            else if (!chk_i[g])      run_cnt <= '0;
            else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
        end

        assign hit_vec[g] = chk_i[g] && (run_cnt >= CNT_TRIG);
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/spi_mon_flags.sv
// Sticky error flags and the interrupt request.
// A set request takes priority over a clear pulse in the same cycle.
module spi_mon_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic pad_clr_i,
    input  logic sec_clr_i,
    input  logic irq_en_i,
    output logic pad_err_o,
    output logic safety_err_o,
    output logic irq_o
);
    // Pad-error flag: set wins, otherwise cleared by its own pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         pad_err_o <= 1'b0;
        else if (set_i)     pad_err_o <= 1'b1;
        else if (pad_clr_i) pad_err_o <= 1'b0;
    end

    // Summary safety flag: set wins, otherwise cleared by its own pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         safety_err_o <= 1'b0;
        else if (set_i)     safety_err_o <= 1'b1;
        else if (sec_clr_i) safety_err_o <= 1'b0;
    end

    assign irq_o = safety_err_o & irq_en_i;
endmodule

// File: rtl/spi_pad_monitor.sv
// SPI host output pad monitor (top).
// Compares the internal drive of chip-select 0, data-out and serial clock
// with the synchronized pad readbacks. It is observe-only and has no path
// back to the pads. Assumes the drive values and flags are synchronous to
// clk and the pad readbacks may be asynchronous.
module spi_pad_monitor
    import spi_mon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned FAULT_THRESH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_mode_i,
    input  logic tx_active_i,
    input  logic mosi_chk_en_i,
    input  logic irq_en_i,
    input  logic drv_cs0_i,
    input  logic drv_mosi_i,
    input  logic drv_sck_i,
    input  logic pad_cs0_i,
    input  logic pad_mosi_i,
    input  logic pad_sck_i,
    input  logic pad_clr_i,
    input  logic sec_clr_i,
    output logic pad_err_o,
    output logic safety_err_o,
    output logic irq_o
);
    localparam int unsigned CTRL_W = 3 + N_LINES;

    line_vec_t drv_raw, pad_raw, drv_d, pad_d, lane_en, chk;
    logic [CTRL_W-1:0] ctrl_raw, ctrl_d;
    logic host_d, tx_d, mosi_en_d, tx_q, cmp_en, set_evt;

    assign drv_raw[LN_CS0]  = drv_cs0_i;
    assign drv_raw[LN_MOSI] = drv_mosi_i;
    assign drv_raw[LN_SCK]  = drv_sck_i;
    assign pad_raw[LN_CS0]  = pad_cs0_i;
    assign pad_raw[LN_MOSI] = pad_mosi_i;
    assign pad_raw[LN_SCK]  = pad_sck_i;
    assign ctrl_raw = {host_mode_i, tx_active_i, mosi_chk_en_i, drv_raw};

    spi_mon_align #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_pad_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pad_raw), .q_o(pad_d)
    );

    spi_mon_align #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_dly (
        .clk(clk), .rst_n(rst_n), .d_i(ctrl_raw), .q_o(ctrl_d)
    );

    assign {host_d, tx_d, mosi_en_d, drv_d} = ctrl_d;

    // Remember the previous aligned transmit flag to blank boundary cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= 1'b0;
        else        tx_q <= tx_d;
    end

    assign cmp_en = host_d && tx_d && (tx_d == tx_q);

    // Per-line participation: data-out only with its own enable.
    always_comb begin
        lane_en          = '1;
        lane_en[LN_MOSI] = mosi_en_d;
    end

    assign chk = (drv_d ^ pad_d) & lane_en & {N_LINES{cmp_en}};

    spi_mon_filter #(.THRESH(FAULT_THRESH)) u_filter (
        .clk(clk), .rst_n(rst_n), .chk_i(chk), .hit_o(set_evt)
    );

    spi_mon_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_evt),
        .pad_clr_i(pad_clr_i), .sec_clr_i(sec_clr_i), .irq_en_i(irq_en_i),
        .pad_err_o(pad_err_o), .safety_err_o(safety_err_o), .irq_o(irq_o)
    );
endmodule

// File: rtl/spi_mon_chk.sv
// Assertion checker for spi_pad_monitor, attached through bind.
module spi_mon_chk #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic host_mode_i,
    input logic irq_en_i,
    input logic pad_clr_i,
    input logic sec_clr_i,
    input logic set_evt,
    input logic pad_err_o,
    input logic safety_err_o,
    input logic irq_o
);
    localparam int unsigned LIM = SYNC_STAGES + 1;
    localparam int unsigned IW  = $clog2(LIM + 1);
    logic [IW-1:0] idle_cnt;

    // Count consecutive cycles out of host mode, saturating at LIM.
    always_ff @(posedge clk) begin
        if (!rst_n || host_mode_i)   idle_cnt <= '0;
        else if (idle_cnt != IW'(LIM)) idle_cnt <= idle_cnt + 1'b1;
    end

    a_r4_idle_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == IW'(LIM)) |-> !set_evt);

    a_r7_safety_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (safety_err_o && !sec_clr_i) |=> safety_err_o);

    a_r7_pad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_err_o && !pad_clr_i) |=> pad_err_o);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> (pad_err_o && safety_err_o));

    a_r7_sec_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_clr_i && !set_evt) |=> !safety_err_o);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (safety_err_o && irq_en_i));

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);

    a_r2_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_err_o) |-> safety_err_o);
endmodule

bind spi_pad_monitor spi_mon_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_mode_i(host_mode_i), .irq_en_i(irq_en_i),
    .pad_clr_i(pad_clr_i), .sec_clr_i(sec_clr_i), .set_evt(set_evt),
    .pad_err_o(pad_err_o), .safety_err_o(safety_err_o), .irq_o(irq_o)
);

// File: tb/test_spi_pad_monitor.sv
module test_spi_pad_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_mode_i = 1'b0, tx_active_i = 1'b0, mosi_chk_en_i = 1'b0, irq_en_i = 1'b0;
    logic drv_cs0_i = 1'b0, drv_mosi_i = 1'b0, drv_sck_i = 1'b0;
    logic pad_cs0_i = 1'b0, pad_mosi_i = 1'b0, pad_sck_i = 1'b0;
    logic pad_clr_i = 1'b0, sec_clr_i = 1'b0;
    logic pad_err_o, safety_err_o, irq_o;

    logic [2:0] inv = 3'b000;   // bit0 cs0, bit1 data-out, bit2 sck
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_pad_monitor i_spi_pad_monitor (.*);

    function automatic bit exp_fault(bit host, bit tx, bit men, int line, int len);
        return host && tx && (line != 1 || men) && (len >= 2);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            {drv_cs0_i, drv_mosi_i, drv_sck_i} = 3'($urandom);
            pad_cs0_i  = drv_cs0_i  ^ inv[0];
            pad_mosi_i = drv_mosi_i ^ inv[1];
            pad_sck_i  = drv_sck_i  ^ inv[2];
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic clear_all();
        pad_clr_i = 1'b1; sec_clr_i = 1'b1;
        cyc(1);
        pad_clr_i = 1'b0; sec_clr_i = 1'b0;
    endtask

    task automatic burst(input int line, input int len);
        inv = 3'b000; inv[line] = 1'b1;
        cyc(len);
        inv = 3'b000;
        cyc(6);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 pad_err", pad_err_o, 1'b0);
        check("R1 safety_err", safety_err_o, 1'b0);
        check("R1 irq", irq_o, 1'b0);

        // R2 directed: sck stuck for 4 cycles
        host_mode_i = 1; tx_active_i = 1; irq_en_i = 1; mosi_chk_en_i = 0;
        cyc(5);
        burst(2, 4);
        check("R2 pad_err", pad_err_o, 1'b1);
        check("R2 safety_err", safety_err_o, 1'b1);
        check("R9 irq on", irq_o, 1'b1);
        irq_en_i = 0; cyc(1);
        check("R9 irq masked", irq_o, 1'b0);
        // R7 separate clears
        pad_clr_i = 1; cyc(1); pad_clr_i = 0;
        check("R7 pad cleared", pad_err_o, 1'b0);
        check("R7 safety kept", safety_err_o, 1'b1);
        sec_clr_i = 1; cyc(1); sec_clr_i = 0;
        check("R7 safety cleared", safety_err_o, 1'b0);

        // R3 alternating single glitches on cs0
        for (int k = 0; k < 4; k++) begin
            inv = 3'b001; cyc(1);
            inv = 3'b000; cyc(1);
        end
        cyc(6);
        check("R3 glitches", pad_err_o, 1'b0);

        // R5 data-out ignored, then checked
        burst(1, 5);
        check("R5 mosi ignored", safety_err_o, 1'b0);
        mosi_chk_en_i = 1; cyc(5);
        burst(1, 2);
        check("R5 mosi checked", pad_err_o, 1'b1);
        clear_all();

        // R8 persistent fault with clear in the same cycle
        inv = 3'b001; cyc(6);
        clear_all();
        check("R8 pad set wins", pad_err_o, 1'b1);
        check("R8 safety set wins", safety_err_o, 1'b1);
        inv = 3'b000; cyc(6);
        clear_all();
        check("R8 cleared after", safety_err_o, 1'b0);

        // R6 blanking at tx rise
        tx_active_i = 0; cyc(5);
        tx_active_i = 1; burst(0, 2);
        check("R6 two-cycle masked", pad_err_o, 1'b0);
        tx_active_i = 0; cyc(5);
        tx_active_i = 1; burst(0, 3);
        check("R6 three-cycle seen", pad_err_o, 1'b1);
        clear_all();

        // R2 R3 R4 R5 random trials
        for (int t = 0; t < 120; t++) begin
            bit h, tx, men;
            int line, len;
            bit e;
            h = 1'($urandom_range(0, 3) != 0);
            tx = 1'($urandom_range(0, 3) != 0);
            men = 1'($urandom);
            line = $urandom_range(0, 2);
            len = $urandom_range(1, 4);
            host_mode_i = h; tx_active_i = tx; mosi_chk_en_i = men;
            irq_en_i = 1'($urandom);
            cyc(5);
            burst(line, len);
            e = exp_fault(h, tx, men, line, len);
            check("R2/R3/R4/R5 random pad_err", pad_err_o, e);
            check("R2 random safety_err", safety_err_o, e);
            check("R9 random irq", irq_o, e & irq_en_i);
            clear_all();
            check("R7 random clear", pad_err_o | safety_err_o, 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule